// File: doc/BRIEF.md
# Multi-mode up/down pulse counter

This block turns activity on two already-synchronised input pins, S0 and S1, into up and down count steps, and applies those steps to a main counter and an auxiliary counter. A mode input selects how steps arise. The single-input modes count one chosen edge of S0, and the direction comes from a configuration bit that S1 can optionally reverse. The quadrature modes decode the two-bit Gray sequence on S0/S1 at one, two or four steps per cycle of S0.

The main counter is CW bits wide (16 by default). It wraps against a TOP value, and it pulses `ovf` or `unf` for one clock when it wraps. A hysteresis option makes both kinds of wrap reload TOP/2. Each counter has its own event filter that admits up steps, down steps, both or neither. Each counter also has its own start and stop inputs. The auxiliary counter wraps against the same TOP but never uses hysteresis and raises no wrap pulses.

Top module: `edge_tally`

## Requirements
- R1: After reset the main and auxiliary counts are 0, `ovf` and `unf` are low, and both counters are running.
- R2: In the single-input modes (mode 1 and mode 2), a rising S0 edge makes one step when `edge_inv` is 0, and a falling S0 edge makes one step when `edge_inv` is 1. The count changes at the first clock edge after the pin change.
- R3: In the single-input modes, a step counts up when `cnt_down` is 0 and down when `cnt_down` is 1.
- R4: When `s1_dir_en` is 1 in a single-input mode, S1 high keeps the direction set by `cnt_down` and S1 low reverses it.
- R5: With `hyst_en` 0, an up step taken while the main count is at or above `top_val` loads 0 and pulses `ovf` for one cycle. A down step taken at 0 loads `top_val` and pulses `unf` for one cycle. `ovf` and `unf` are never high together.
- R6: With `hyst_en` 1, both kinds of wrap load `top_val >> 1` instead, and they still pulse `ovf` or `unf`.
- R7: The quadrature modes take {S0,S1} positions in the forward order 00, 10, 11, 01 as up steps and the reverse order as down steps. Mode 6 steps on every single-pin change. Mode 5 steps only on S0 changes. Mode 4 and mode 3 step only on S0 changes made while S1 is low.
- R8: In the quadrature modes, `edge_inv` = 1 inverts the direction, and `cnt_down` has no effect.
- R9: The main event select `main_evsel` admits up steps when bit 0 is set and down steps when bit 1 is set: 00 none, 01 up only, 10 down only, 11 both. A step that is not admitted leaves the count unchanged.
- R10: `aux_evsel` uses the same encoding for the auxiliary counter, and its tied-low value 00 means none. The auxiliary counter wraps at `top_val` like the main counter but never applies hysteresis.
- R11: A stop pulse halts its counter from the next clock on, and the counter then holds its value. A start pulse resumes it. When start and stop arrive together, stop wins. The two counters are gated independently.
- R12: Mode 0 (disabled), and the unused code 7, produce no steps, so both counts hold.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| s0_in | input | 1 | Synchronised pin S0 |
| s1_in | input | 1 | Synchronised pin S1 |
| mode | input | 3 | Operating mode, 0 to 6 |
| edge_inv | input | 1 | Selects the counted edge (single modes) or inverts direction (quadrature modes) |
| cnt_down | input | 1 | Count direction in the single-input modes |
| s1_dir_en | input | 1 | Lets S1 low reverse the single-input direction |
| hyst_en | input | 1 | Wraps of the main counter reload TOP/2 |
| main_evsel | input | 2 | Main counter event filter |
| aux_evsel | input | 2 | Auxiliary counter event filter |
| top_val | input | CW | Wrap limit |
| main_start | input | 1 | Resume the main counter |
| main_stop | input | 1 | Halt the main counter |
| aux_start | input | 1 | Resume the auxiliary counter |
| aux_stop | input | 1 | Halt the auxiliary counter |
| count | output | CW | Main counter value |
| aux_count | output | CW | Auxiliary counter value |
| ovf | output | 1 | One-cycle main overflow pulse |
| unf | output | 1 | One-cycle main underflow pulse |

## Verification
Single-edge pulse trains are run with each polarity and direction setting, and with S1 held high and then low. These show which edge counts and which way it counts. Gray-code walks in both rotations are played through every quadrature resolution, so a decoder that confused 1X with 2X, or forward with reverse, yields a different count. Runs across a small TOP, with and without hysteresis, separate the three reload values. Reverse walks under the up-only and down-only filters, plus stop, start and simultaneous stop-and-start pulses, show that the two counters are gated separately.

// File: rtl/edge_tally_pkg.sv
package edge_tally_pkg;

  typedef enum logic [2:0] {
    MODE_OFF        = 3'd0,
    MODE_OVS_SINGLE = 3'd1,
    MODE_EXT_SINGLE = 3'd2,
    MODE_EXT_QUAD   = 3'd3,
    MODE_QUAD_X1    = 3'd4,
    MODE_QUAD_X2    = 3'd5,
    MODE_QUAD_X4    = 3'd6
  } tally_mode_e;

  // One decoded step; at most one of the two bits is set.
  typedef struct packed {
    logic up;
    logic dn;
  } step_t;

  // Admit a step through a two-bit filter (bit0 = up, bit1 = down).
  function automatic step_t filter_step(input logic [1:0] sel, input step_t s);
    step_t r;
    r.up = s.up & sel[0];
    r.dn = s.dn & sel[1];
    return r;
  endfunction

endpackage

// File: rtl/edge_tally_decode.sv
module edge_tally_decode
  import edge_tally_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        s0,
  input  logic        s1,
  input  logic [2:0]  mode,
  input  logic        edge_inv,
  input  logic        cnt_down,
  input  logic        s1_dir_en,
  output step_t       step
);

  tally_mode_e mode_e;
  assign mode_e = tally_mode_e'(mode);

  logic p0, p1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      p0 <= 1'b0;
      p1 <= 1'b0;
    end else begin
      p0 <= s0;
      p1 <= s1;
    end
  end

  // Single-input path
  logic s0_rise, s0_fall, single_ev, single_dn;
  assign s0_rise   = s0 & ~p0;
  assign s0_fall   = ~s0 & p0;
  assign single_ev = edge_inv ? s0_fall : s0_rise;
  assign single_dn = cnt_down ^ (s1_dir_en & ~s1);

  // Quadrature path
  logic ch0, ch1, fwd, quad_up;
  logic q_x4, q_x2, q_x1;
  assign ch0     = s0 ^ p0;
  assign ch1     = s1 ^ p1;
  assign fwd     = ch0 ? (s0 ^ s1) : ~(s0 ^ s1);
  assign quad_up = fwd ^ edge_inv;
  assign q_x4    = ch0 ^ ch1;
  assign q_x2    = ch0 & ~ch1;
  assign q_x1    = ch0 & ~ch1 & ~s1;

  always_comb begin
    step = '0;
    unique case (mode_e)
      MODE_OVS_SINGLE, MODE_EXT_SINGLE: begin
        step.up = single_ev & ~single_dn;
        step.dn = single_ev & single_dn;
      end
      MODE_EXT_QUAD, MODE_QUAD_X1: begin
        step.up = q_x1 & quad_up;
        step.dn = q_x1 & ~quad_up;
      end
      MODE_QUAD_X2: begin
        step.up = q_x2 & quad_up;
        step.dn = q_x2 & ~quad_up;
      end
      MODE_QUAD_X4: begin
        step.up = q_x4 & quad_up;
        step.dn = q_x4 & ~quad_up;
      end
      default: step = '0;
    endcase
  end

endmodule

// File: rtl/edge_tally_ctr.sv
module edge_tally_ctr
  import edge_tally_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         go,
  input  logic         halt,
  input  logic [1:0]   sel,
  input  step_t        ev,
  input  logic [W-1:0] lim,
  input  logic         hy,
  output logic [W-1:0] value,
  output logic         wrap_up,
  output logic         wrap_dn
);

  function automatic logic [W-1:0] next_up(input logic [W-1:0] v,
                                           input logic [W-1:0] l,
                                           input logic h);
    if (v >= l) return h ? (l >> 1) : '0;
    return v + W'(1);
  endfunction

  function automatic logic [W-1:0] next_dn(input logic [W-1:0] v,
                                           input logic [W-1:0] l,
                                           input logic h);
    if (v == '0) return h ? (l >> 1) : l;
    return v - W'(1);
  endfunction

  logic  running;
  step_t admitted;
  logic  take_up, take_dn;

  assign admitted = filter_step(sel, ev);
  assign take_up  = running & admitted.up;
  assign take_dn  = running & admitted.dn;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    running <= 1'b1;
    else if (halt) running <= 1'b0;
    else if (go)   running <= 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      value   <= '0;
      wrap_up <= 1'b0;
      wrap_dn <= 1'b0;
    end else begin
      wrap_up <= take_up & (value >= lim);
      wrap_dn <= take_dn & (value == '0);
      if (take_up)      value <= next_up(value, lim, hy);
      else if (take_dn) value <= next_dn(value, lim, hy);
    end
  end

endmodule

// File: rtl/edge_tally.sv
module edge_tally
  import edge_tally_pkg::*;
#(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          s0_in,
  input  logic          s1_in,
  input  logic [2:0]    mode,
  input  logic          edge_inv,
  input  logic          cnt_down,
  input  logic          s1_dir_en,
  input  logic          hyst_en,
  input  logic [1:0]    main_evsel,
  input  logic [1:0]    aux_evsel,
  input  logic [CW-1:0] top_val,
  input  logic          main_start,
  input  logic          main_stop,
  input  logic          aux_start,
  input  logic          aux_stop,
  output logic [CW-1:0] count,
  output logic [CW-1:0] aux_count,
  output logic          ovf,
  output logic          unf
);

  localparam int CNT_N = 2;

  step_t step;

  edge_tally_decode u_dec (
    .clk       (clk),
    .rst_n     (rst_n),
    .s0        (s0_in),
    .s1        (s1_in),
    .mode      (mode),
    .edge_inv  (edge_inv),
    .cnt_down  (cnt_down),
    .s1_dir_en (s1_dir_en),
    .step      (step)
  );

  logic [1:0]    sel_a   [CNT_N];
  logic          go_a    [CNT_N];
  logic          halt_a  [CNT_N];
  logic          hy_a    [CNT_N];
  logic [CW-1:0] val_a   [CNT_N];
  logic          wup_a   [CNT_N];
  logic          wdn_a   [CNT_N];

  assign sel_a[0]  = main_evsel;
  assign sel_a[1]  = aux_evsel;
  assign go_a[0]   = main_start;
  assign go_a[1]   = aux_start;
  assign halt_a[0] = main_stop;
  assign halt_a[1] = aux_stop;
  assign hy_a[0]   = hyst_en;
  assign hy_a[1]   = 1'b0;

  for (genvar i = 0; i < CNT_N; i++) begin : g_ctr
    edge_tally_ctr #(.W(CW)) u_ctr (
      .clk     (clk),
      .rst_n   (rst_n),
      .go      (go_a[i]),
      .halt    (halt_a[i]),
      .sel     (sel_a[i]),
      .ev      (step),
      .lim     (top_val),
      .hy      (hy_a[i]),
      .value   (val_a[i]),
      .wrap_up (wup_a[i]),
      .wrap_dn (wdn_a[i])
    );
  end

  logic aux_wrap_unused;
  assign aux_wrap_unused = wup_a[1] | wdn_a[1];

  assign count     = val_a[0];
  assign aux_count = val_a[1];
  assign ovf       = wup_a[0];
  assign unf       = wdn_a[0];

endmodule

// File: rtl/edge_tally_chk.sv
module edge_tally_chk #(
  parameter int CW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic [2:0]    mode,
  input logic          hyst_en,
  input logic [1:0]    main_evsel,
  input logic [1:0]    aux_evsel,
  input logic [CW-1:0] top_val,
  input logic [CW-1:0] count,
  input logic [CW-1:0] aux_count,
  input logic          ovf,
  input logic          unf
);

  AST_OFF_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 3'd0) |=> ($stable(count) && $stable(aux_count))) else $error("off mode moved a count"); // R12

  AST_OVF_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    ovf |-> (count == ($past(hyst_en) ? ($past(top_val) >> 1) : CW'(0)))) else $error("bad overflow reload"); // R5, R6

  AST_UNF_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    unf |-> (count == ($past(hyst_en) ? ($past(top_val) >> 1) : $past(top_val)))) else $error("bad underflow reload"); // R5, R6

  AST_FLAGS_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(ovf && unf)) else $error("both wrap flags"); // R5

  AST_MAIN_SEL_NONE: assert property (@(posedge clk) disable iff (!rst_n)
    (main_evsel == 2'b00) |=> ($stable(count) && !ovf && !unf)) else $error("filtered main moved"); // R9

  AST_AUX_SEL_NONE: assert property (@(posedge clk) disable iff (!rst_n)
    (aux_evsel == 2'b00) |=> $stable(aux_count)) else $error("filtered aux moved"); // R10

endmodule

bind edge_tally edge_tally_chk #(.CW(CW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .mode       (mode),
  .hyst_en    (hyst_en),
  .main_evsel (main_evsel),
  .aux_evsel  (aux_evsel),
  .top_val    (top_val),
  .count      (count),
  .aux_count  (aux_count),
  .ovf        (ovf),
  .unf        (unf)
);

// File: tb/sim_edge_tally.sv
`timescale 1ns/1ps
module sim_edge_tally;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        s0_in = 1'b0, s1_in = 1'b0;
  logic [2:0]  mode = 3'd0;
  logic        edge_inv = 1'b0, cnt_down = 1'b0, s1_dir_en = 1'b0, hyst_en = 1'b0;
  logic [1:0]  main_evsel = 2'b00, aux_evsel = 2'b00;
  logic [15:0] top_val = 16'hFFFF;
  logic        main_start = 1'b0, main_stop = 1'b0, aux_start = 1'b0, aux_stop = 1'b0;
  logic [15:0] count, aux_count;
  logic        ovf, unf;

  always #2 clk = ~clk;

  edge_tally u0 (
    .clk(clk), .rst_n(rst_n), .s0_in(s0_in), .s1_in(s1_in), .mode(mode),
    .edge_inv(edge_inv), .cnt_down(cnt_down), .s1_dir_en(s1_dir_en),
    .hyst_en(hyst_en), .main_evsel(main_evsel), .aux_evsel(aux_evsel),
    .top_val(top_val), .main_start(main_start), .main_stop(main_stop),
    .aux_start(aux_start), .aux_stop(aux_stop), .count(count),
    .aux_count(aux_count), .ovf(ovf), .unf(unf)
  );

  typedef struct {
    int          due;
    logic [15:0] c;
    logic [15:0] a;
    logic        o;
    logic        u;
    string       req;
  } exp_t;

  exp_t q[$];
  exp_t got;
  int   cyc = 0;
  int   checks = 0;
  int   errors = 0;
  bit   done = 1'b0;

  // Reference state kept by the bench
  logic [15:0] m_cnt = '0, m_aux = '0;
  logic        m_p0 = 1'b0, m_p1 = 1'b0, m_run = 1'b1, m_arun = 1'b1;
  logic        cur_a = 1'b0, cur_b = 1'b0;
  int          qpos = 0;

  always @(posedge clk) cyc <= cyc + 1;

  // Monitor: compare the oldest expectation when it falls due
  always @(negedge clk) begin
    if (q.size() > 0 && q[0].due == cyc) begin
      got = q.pop_front();
      checks++;
      if (count !== got.c || aux_count !== got.a || ovf !== got.o || unf !== got.u) begin
        errors++;
        $display("FAIL %s: cnt=%h exp %h aux=%h exp %h ovf=%b exp %b unf=%b exp %b",
                 got.req, count, got.c, aux_count, got.a, ovf, got.o, unf, got.u);
      end
    end
  end

  function automatic int gray_pos(input logic a, input logic b);
    case ({a, b})
      2'b00: return 0;
      2'b10: return 1;
      2'b11: return 2;
      default: return 3;
    endcase
  endfunction

  // Driver: apply one cycle of pins and controls, predict, enqueue
  task automatic step(input logic a, input logic b, input logic [3:0] ctl, input string req);
    logic up, dn, o, u;
    exp_t e;
    s0_in = a; s1_in = b;
    main_start = ctl[0]; main_stop = ctl[1]; aux_start = ctl[2]; aux_stop = ctl[3];
    up = 1'b0; dn = 1'b0; o = 1'b0; u = 1'b0;
    if (mode == 3'd1 || mode == 3'd2) begin
      logic hit, goes_down;
      hit = edge_inv ? (m_p0 && !a) : (!m_p0 && a);
      goes_down = cnt_down ? !(s1_dir_en && !b) : (s1_dir_en && !b);
      up = hit && !goes_down;
      dn = hit && goes_down;
    end else if (mode >= 3'd3 && mode <= 3'd6) begin
      int d;
      logic moved, ok, dir_up;
      d = (gray_pos(a, b) - gray_pos(m_p0, m_p1) + 4) % 4;
      moved = (d == 1) || (d == 3);
      if (mode == 3'd6)      ok = moved;
      else if (mode == 3'd5) ok = moved && (a != m_p0);
      else                   ok = moved && (a != m_p0) && !b;
      dir_up = (d == 1) != edge_inv;
      up = ok && dir_up;
      dn = ok && !dir_up;
    end
    if (m_run && up && main_evsel[0]) begin
      if (m_cnt >= top_val) begin m_cnt = hyst_en ? top_val / 2 : 16'd0; o = 1'b1; end
      else m_cnt = m_cnt + 16'd1;
    end else if (m_run && dn && main_evsel[1]) begin
      if (m_cnt == 16'd0) begin m_cnt = hyst_en ? top_val / 2 : top_val; u = 1'b1; end
      else m_cnt = m_cnt - 16'd1;
    end
    if (m_arun && up && aux_evsel[0])
      m_aux = (m_aux >= top_val) ? 16'd0 : m_aux + 16'd1;
    else if (m_arun && dn && aux_evsel[1])
      m_aux = (m_aux == 16'd0) ? top_val : m_aux - 16'd1;
    if (ctl[1]) m_run = 1'b0; else if (ctl[0]) m_run = 1'b1;
    if (ctl[3]) m_arun = 1'b0; else if (ctl[2]) m_arun = 1'b1;
    m_p0 = a; m_p1 = b;
    cur_a = a; cur_b = b;
    e.due = cyc + 1; e.c = m_cnt; e.a = m_aux; e.o = o; e.u = u; e.req = req;
    q.push_back(e);
    @(negedge clk);
  endtask

  task automatic pulses(input int n, input logic b, input string req);
    for (int i = 0; i < n; i++) begin
      step(1'b1, b, 4'd0, req);
      step(1'b0, b, 4'd0, req);
    end
  endtask

  task automatic walk(input int n, input bit forward, input string req);
    for (int i = 0; i < n; i++) begin
      qpos = forward ? (qpos + 1) % 4 : (qpos + 3) % 4;
      case (qpos)
        0: step(1'b0, 1'b0, 4'd0, req);
        1: step(1'b1, 1'b0, 4'd0, req);
        2: step(1'b1, 1'b1, 4'd0, req);
        default: step(1'b0, 1'b1, 4'd0, req);
      endcase
    end
  endtask

  task automatic idle(input int n, input logic [3:0] ctl, input string req);
    for (int i = 0; i < n; i++) step(cur_a, cur_b, ctl, req);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    checks++;
    if (count !== 16'd0 || aux_count !== 16'd0 || ovf !== 1'b0 || unf !== 1'b0) begin
      errors++;
      $display("FAIL R1: cnt=%h aux=%h ovf=%b unf=%b exp 0 0 0 0", count, aux_count, ovf, unf);
    end
    idle(2, 4'd0, "R1");

    // R12: disabled mode ignores activity
    main_evsel = 2'b11;
    pulses(2, 1'b0, "R12");

    // R2: rising then falling edges
    mode = 3'd1;
    pulses(3, 1'b0, "R2");
    edge_inv = 1'b1;
    pulses(2, 1'b0, "R2");
    edge_inv = 1'b0;
    mode = 3'd2;
    pulses(1, 1'b0, "R2");

    // R3: count down
    cnt_down = 1'b1;
    pulses(2, 1'b0, "R3");
    cnt_down = 1'b0;

    // R4: S1 controls direction
    s1_dir_en = 1'b1;
    pulses(1, 1'b1, "R4");
    pulses(2, 1'b0, "R4");
    s1_dir_en = 1'b0;

    // R5: wrap against a small TOP
    top_val = 16'd5;
    pulses(6, 1'b0, "R5");
    cnt_down = 1'b1;
    pulses(5, 1'b0, "R5");
    cnt_down = 1'b0;

    // R6: hysteresis reload
    hyst_en = 1'b1;
    top_val = 16'd6;
    pulses(6, 1'b0, "R6");
    cnt_down = 1'b1;
    pulses(6, 1'b0, "R6");
    cnt_down = 1'b0;
    hyst_en = 1'b0;
    top_val = 16'hFFFF;

    // R7: quadrature resolutions
    idle(1, 4'd0, "R7");
    qpos = gray_pos(cur_a, cur_b);
    mode = 3'd6;
    walk(8, 1'b1, "R7");
    walk(3, 1'b0, "R7");
    mode = 3'd5;
    walk(8, 1'b1, "R7");
    mode = 3'd4;
    walk(8, 1'b1, "R7");
    walk(8, 1'b0, "R7");
    mode = 3'd3;
    walk(4, 1'b1, "R7");

    // R8: polarity inverts, direction bit ignored
    mode = 3'd6;
    edge_inv = 1'b1;
    walk(4, 1'b1, "R8");
    edge_inv = 1'b0;
    cnt_down = 1'b1;
    walk(4, 1'b1, "R8");
    cnt_down = 1'b0;

    // R9: main event filter
    main_evsel = 2'b01;
    walk(4, 1'b0, "R9");
    walk(2, 1'b1, "R9");
    main_evsel = 2'b10;
    walk(3, 1'b1, "R9");
    walk(2, 1'b0, "R9");
    main_evsel = 2'b00;
    walk(4, 1'b1, "R9");
    main_evsel = 2'b11;

    // R10: auxiliary counter filter and wrap
    aux_evsel = 2'b11;
    walk(4, 1'b1, "R10");
    aux_evsel = 2'b10;
    walk(6, 1'b0, "R10");
    aux_evsel = 2'b01;
    walk(2, 1'b0, "R10");
    aux_evsel = 2'b11;

    // R11: independent start and stop
    idle(1, 4'b0010, "R11");
    walk(4, 1'b1, "R11");
    idle(1, 4'b1001, "R11");
    walk(3, 1'b1, "R11");
    idle(1, 4'b0100, "R11");
    idle(1, 4'b0011, "R11");
    walk(2, 1'b1, "R11");
    idle(1, 4'b0001, "R11");
    walk(2, 1'b1, "R11");

    // R12: disabled and unused mode codes
    mode = 3'd0;
    walk(4, 1'b1, "R12");
    mode = 3'd7;
    walk(4, 1'b1, "R12");

    idle(3, 4'd0, "R12");
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not complete, exp completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule